// File: doc/BRIEF.md
# NAND Page-Read and Identify Sequencer

This block drives an 8-bit asynchronous NAND flash bus for the two read-side jobs that a storage controller needs at bring-up and during normal operation. The first job is reading the device identity. The second is fetching bytes from a page. A single start pulse launches one operation. The operation type, the bank, the column and row addresses, the number of column and row address cycles and the byte count are all captured on that pulse.

For either operation the sequencer selects one bank and builds every write and read strobe from three phases: setup, pulse and hold. It places commands and address bytes on the bus with the command-latch or address-latch line raised. A page read waits for the device ready line, and the wait has a cycle limit. Each byte read from the device is handed out on a valid/ready stream. When the operation finishes or aborts, the bank is released. Completion is reported by a single-cycle done pulse, and an abort by a single-cycle error pulse.

Top module: `nand_rd_seq`

## Requirements
- R1: Out of reset and whenever no operation is in progress, both chip-enable lines are high (`nand_ce_n == 2'b11`), the secondary select is low, `nand_we_n` and `nand_re_n` are high, and `busy`, `done`, `err` and `m_valid` are low.
- R2: During an operation, bank bit 0 picks the chip enable: 0 gives `nand_ce_n == 2'b10` and 1 gives `nand_ce_n == 2'b01`, so exactly one is ever low. Bank bit 1 drives `nand_sel2`. Both hold steady for the whole operation.
- R3: An identify operation (`op_ident = 1`) issues three write strobes in order: command 0xFF, command 0x90, then address byte 0x00. It then performs five read strobes and streams the five bytes in the order they were read. It does not wait on the ready line.
- R4: A page read (`op_ident = 0`) issues, in order, command 0x00, `col_cycles` column bytes, `row_cycles` row bytes and command 0x30. After that it does not lower `nand_re_n` until `nand_rb` has been sampled high. Commands are marked by `nand_cle` and address bytes by `nand_ale`.
- R5: Address byte k of the column is `col_addr[8k+7:8k]`, least significant byte first. The row follows the same rule. Cycles beyond the field width send 0x00, and a cycle count of zero skips that field.
- R6: A page read delivers exactly `byte_count` bytes. A count of zero completes after ready with no read strobe and no stream data.
- R7: Write strobes hold `nand_we_n` low for the pulse length and keep it high for hold plus setup between consecutive write bytes. Page reads use a 3-cycle pulse and a 2-cycle gap. Identify uses the slow timing: a 5-cycle pulse and a 6-cycle gap. The write and read strobes are never low together.
- R8: `nand_wp_n` is low (write-protected) for the whole of every operation.
- R9: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold. No read strobe starts while a byte is waiting on the stream.
- R10: A page read aborts when `nand_rb` is sampled low in TMO_CYCLES consecutive cycles of the ready wait. The abort releases the bank and pulses `err` instead of `done`. If ready is seen in the same cycle the limit is reached, the read proceeds.
- R11: `done` is a one-cycle pulse in the cycle after the last stream transfer, and `nand_ce_n == 2'b11` and `busy == 0` in that cycle.
- R12: A start pulse while busy is ignored, and inputs changed mid-operation have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| op_ident | input | 1 | 1 = identify, 0 = page read |
| bank | input | 2 | Bank number |
| col_addr | input | COL_W | Column address |
| row_addr | input | ROW_W | Row address |
| col_cycles | input | CYC_W | Column address bytes to send |
| row_cycles | input | CYC_W | Row address bytes to send |
| byte_count | input | CNT_W | Bytes to read in a page read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle ready-timeout pulse |
| m_valid | output | 1 | Stream byte valid |
| m_data | output | 8 | Stream byte |
| m_ready | input | 1 | Stream consumer ready |
| nand_ce_n | output | 2 | Chip enables, active low |
| nand_sel2 | output | 1 | Secondary bank select |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus byte from device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
Two events can fall in the same cycle: the ready line returning high, and the ready-wait counter reaching its limit. The bench's device model keeps the ready line low for a chosen number of cycles after the confirm command. With one setting, ready is first sampled high exactly on the final permitted wait cycle, and the read must complete with all its data. With a setting one cycle longer, the same operation must end with the error pulse, no done and no data. The other collision is between a waiting stream byte and the next read strobe. It is provoked with a stalling consumer and judged by checking that the byte holds and that the read strobe stays high.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int TIM_W    = 4;
    localparam int ID_BYTES = 5;

    localparam logic [7:0] CMD_RESET   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_PAGE_RD = 8'h00;
    localparam logic [7:0] CMD_CONFIRM = 8'h30;
    localparam logic [7:0] ID_ADDR     = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_CMD,
        ST_ID_CMD,
        ST_ID_ADDR,
        ST_RD_CMD,
        ST_COL,
        ST_ROW,
        ST_CONF,
        ST_WAIT,
        ST_READ,
        ST_OUT
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_PULSE,
        PH_HOLD
    } strobe_ph_e;

    typedef struct packed {
        logic [TIM_W-1:0] setup;
        logic [TIM_W-1:0] pulse;
        logic [TIM_W-1:0] hold;
    } strobe_tim_t;

    function automatic logic [TIM_W-1:0] clamp_len(input int v);
        if (v < 1)
            return TIM_W'(1);
        else if (v > (1 << TIM_W) - 1)
            return {TIM_W{1'b1}};
        else
            return TIM_W'(v);
    endfunction

    function automatic logic is_cmd_state(input seq_state_e s);
        return (s == ST_RST_CMD) || (s == ST_ID_CMD) ||
               (s == ST_RD_CMD)  || (s == ST_CONF);
    endfunction

    function automatic logic is_addr_state(input seq_state_e s);
        return (s == ST_ID_ADDR) || (s == ST_COL) || (s == ST_ROW);
    endfunction

endpackage

// File: rtl/nrs_bank_decode.sv
module nrs_bank_decode (
    input  logic       active,
    input  logic [1:0] bank,
    output logic [1:0] ce_n,
    output logic       sel2,
    output logic       wp_n
);
    always_comb begin
        if (!active) begin
            ce_n = 2'b11;
            sel2 = 1'b0;
        end else begin
            ce_n = bank[0] ? 2'b01 : 2'b10;
            sel2 = bank[1];
        end
        wp_n = ~active;
    end
endmodule

// File: rtl/nrs_strobe_timer.sv
module nrs_strobe_timer
    import nrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  strobe_tim_t tim,
    output logic        in_pulse,
    output logic        last_pulse,
    output logic        byte_end
);
    strobe_ph_e       ph;
    logic [TIM_W-1:0] cnt;
    logic [TIM_W-1:0] len;
    logic             ph_last;

    always_comb begin
        case (ph)
            PH_SETUP: len = tim.setup;
            PH_PULSE: len = tim.pulse;
            default:  len = tim.hold;
        endcase
    end

    assign ph_last = (cnt == len - TIM_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph  <= PH_SETUP;
            cnt <= '0;
        end else if (ph_last) begin
            cnt <= '0;
            case (ph)
                PH_SETUP: ph <= PH_PULSE;
                PH_PULSE: ph <= PH_HOLD;
                default:  ph <= PH_SETUP;
            endcase
        end else begin
            cnt <= cnt + TIM_W'(1);
        end
    end

    assign in_pulse   = run && (ph == PH_PULSE);
    assign last_pulse = in_pulse && ph_last;
    assign byte_end   = run && (ph == PH_HOLD) && ph_last;

    // R7: the pulse phase never outlasts its programmed length
    p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
        (run && ph == PH_PULSE) |-> (cnt < tim.pulse));

    // R7: a phase counter left idle always restarts from setup
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ph == PH_SETUP && cnt == '0));

endmodule

// File: rtl/nrs_addr_ser.sv
module nrs_addr_ser #(
    parameter int COL_W = 16,
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COL_W-1:0] col_in,
    input  logic [ROW_W-1:0] row_in,
    input  logic             shift_col,
    input  logic             shift_row,
    output logic [7:0]       col_byte,
    output logic [7:0]       row_byte
);
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q <= '0;
            row_q <= '0;
        end else if (load) begin
            col_q <= col_in;
            row_q <= row_in;
        end else begin
            if (shift_col) col_q <= col_q >> 8;
            if (shift_row) row_q <= row_q >> 8;
        end
    end

    assign col_byte = col_q[7:0];
    assign row_byte = row_q[7:0];
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
    import nrs_pkg::*;
#(
    parameter int COL_W      = 16,
    parameter int ROW_W      = 24,
    parameter int CYC_W      = 3,
    parameter int CNT_W      = 16,
    parameter int TMO_CYCLES = 1024,
    parameter int NRM_SETUP  = 1,
    parameter int NRM_PULSE  = 3,
    parameter int NRM_HOLD   = 1,
    parameter int ID_SETUP   = 3,
    parameter int ID_PULSE   = 5,
    parameter int ID_HOLD    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             op_ident,
    input  logic [1:0]       bank,
    input  logic [COL_W-1:0] col_addr,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [CYC_W-1:0] col_cycles,
    input  logic [CYC_W-1:0] row_cycles,
    input  logic [CNT_W-1:0] byte_count,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             m_valid,
    output logic [7:0]       m_data,
    input  logic             m_ready,
    output logic [1:0]       nand_ce_n,
    output logic             nand_sel2,
    output logic             nand_wp_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

    localparam strobe_tim_t TIM_NRM = '{setup: clamp_len(NRM_SETUP),
                                        pulse: clamp_len(NRM_PULSE),
                                        hold:  clamp_len(NRM_HOLD)};
    localparam strobe_tim_t TIM_ID  = '{setup: clamp_len(ID_SETUP),
                                        pulse: clamp_len(ID_PULSE),
                                        hold:  clamp_len(ID_HOLD)};

    seq_state_e       state;
    logic [1:0]       bank_q;
    logic             id_q;
    logic [CYC_W-1:0] ncol_q;
    logic [CYC_W-1:0] nrow_q;
    logic [CNT_W-1:0] rem_q;
    logic [7:0]       data_q;
    logic [TMO_W-1:0] wcnt;
    logic             done_q;
    logic             err_q;

    logic             run;
    logic             in_pulse;
    logic             last_pulse;
    logic             byte_end;
    logic             take;
    logic [7:0]       col_byte;
    logic [7:0]       row_byte;
    strobe_tim_t      tim_sel;

    assign take    = (state == ST_IDLE) && start;
    assign run     = is_cmd_state(state) || is_addr_state(state) || (state == ST_READ);
    assign tim_sel = id_q ? TIM_ID : TIM_NRM;

    nrs_strobe_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tim        (tim_sel),
        .in_pulse   (in_pulse),
        .last_pulse (last_pulse),
        .byte_end   (byte_end)
    );

    nrs_addr_ser #(.COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .col_in    (col_addr),
        .row_in    (row_addr),
        .shift_col ((state == ST_COL) && byte_end),
        .shift_row ((state == ST_ROW) && byte_end),
        .col_byte  (col_byte),
        .row_byte  (row_byte)
    );

    nrs_bank_decode u_bank (
        .active (state != ST_IDLE),
        .bank   (bank_q),
        .ce_n   (nand_ce_n),
        .sel2   (nand_sel2),
        .wp_n   (nand_wp_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bank_q <= '0;
            id_q   <= 1'b0;
            ncol_q <= '0;
            nrow_q <= '0;
            rem_q  <= '0;
            data_q <= '0;
            wcnt   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            wcnt   <= '0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        bank_q <= bank;
                        id_q   <= op_ident;
                        ncol_q <= col_cycles;
                        nrow_q <= row_cycles;
                        rem_q  <= op_ident ? CNT_W'(ID_BYTES) : byte_count;
                        state  <= op_ident ? ST_RST_CMD : ST_RD_CMD;
                    end
                end
                ST_RST_CMD: if (byte_end) state <= ST_ID_CMD;
                ST_ID_CMD:  if (byte_end) state <= ST_ID_ADDR;
                ST_ID_ADDR: if (byte_end) state <= ST_READ;
                ST_RD_CMD: begin
                    if (byte_end) begin
                        if (ncol_q != '0)      state <= ST_COL;
                        else if (nrow_q != '0) state <= ST_ROW;
                        else                   state <= ST_CONF;
                    end
                end
                ST_COL: begin
                    if (byte_end) begin
                        ncol_q <= ncol_q - CYC_W'(1);
                        if (ncol_q == CYC_W'(1))
                            state <= (nrow_q != '0) ? ST_ROW : ST_CONF;
                    end
                end
                ST_ROW: begin
                    if (byte_end) begin
                        nrow_q <= nrow_q - CYC_W'(1);
                        if (nrow_q == CYC_W'(1)) state <= ST_CONF;
                    end
                end
                ST_CONF: if (byte_end) state <= ST_WAIT;
                ST_WAIT: begin
                    if (nand_rb) begin
                        if (rem_q == '0) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_READ;
                        end
                    end else if (wcnt == TMO_LAST) begin
                        state <= ST_IDLE;
                        err_q <= 1'b1;
                    end else begin
                        wcnt <= wcnt + TMO_W'(1);
                    end
                end
                ST_READ: begin
                    if (last_pulse) data_q <= nand_dq_in;
                    if (byte_end)   state  <= ST_OUT;
                end
                ST_OUT: begin
                    if (m_ready) begin
                        rem_q <= rem_q - CNT_W'(1);
                        if (rem_q == CNT_W'(1)) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_RST_CMD: nand_dq_out = CMD_RESET;
            ST_ID_CMD:  nand_dq_out = CMD_IDENT;
            ST_ID_ADDR: nand_dq_out = ID_ADDR;
            ST_RD_CMD:  nand_dq_out = CMD_PAGE_RD;
            ST_COL:     nand_dq_out = col_byte;
            ST_ROW:     nand_dq_out = row_byte;
            ST_CONF:    nand_dq_out = CMD_CONFIRM;
            default:    nand_dq_out = 8'h00;
        endcase
    end

    assign nand_cle   = is_cmd_state(state);
    assign nand_ale   = is_addr_state(state);
    assign nand_dq_oe = nand_cle || nand_ale;
    assign nand_we_n  = !(nand_dq_oe && in_pulse);
    assign nand_re_n  = !((state == ST_READ) && in_pulse);
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign err        = err_q;
    assign m_valid    = (state == ST_OUT);
    assign m_data     = data_q;

    // R1: nothing is selected or strobed when idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (nand_ce_n == 2'b11 && !nand_sel2 && nand_we_n && nand_re_n));

    // R2: exactly one chip enable is low while an operation runs
    p_ce_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(~nand_ce_n) == 1));

    // R2: the bank selection holds for the whole operation
    p_bank_steady_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(nand_ce_n) && $stable(nand_sel2)));

    // R8: write protect held during every operation
    p_wp_held_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !nand_wp_n);

    // R9: a stalled byte keeps its value
    p_hold_byte_r9: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R9: no read strobe while a byte waits on the stream
    p_no_re_pending_r9: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> nand_re_n);

    // R7: write and read strobes never overlap
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R10: an abort and a completion never coincide
    p_end_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R10: the error pulse leaves the bank released
    p_err_release_r10: assert property (@(posedge clk) disable iff (rst)
        err |-> (nand_ce_n == 2'b11 && !busy));

    // R11: done arrives with the bank released
    p_done_release_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> (nand_ce_n == 2'b11 && !busy));

endmodule

// File: tb/nand_rd_seq_tb.sv
`timescale 1ns/1ps
module nand_rd_seq_tb;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_ident = 1'b0;
    logic [1:0]  bank = '0;
    logic [15:0] col_addr = '0;
    logic [23:0] row_addr = '0;
    logic [2:0]  col_cycles = '0;
    logic [2:0]  row_cycles = '0;
    logic [15:0] byte_count = '0;
    logic        busy, done, err, m_valid;
    logic [7:0]  m_data;
    logic        m_ready = 1'b1;
    logic [1:0]  nand_ce_n;
    logic        nand_sel2, nand_wp_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in;
    logic        rb = 1'b1;

    always #2.5 clk = ~clk;

    nand_rd_seq #(.TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_ident(op_ident), .bank(bank),
        .col_addr(col_addr), .row_addr(row_addr), .col_cycles(col_cycles),
        .row_cycles(row_cycles), .byte_count(byte_count), .busy(busy), .done(done),
        .err(err), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
        .nand_ce_n(nand_ce_n), .nand_sel2(nand_sel2), .nand_wp_n(nand_wp_n),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(rb)
    );

    int total = 0;
    int bad = 0;

    logic [7:0] exp_q[$];
    logic [8:0] exp_bus[$];
    string      cur_req = "R3";
    logic [1:0] exp_ce = 2'b11;
    logic       exp_sel = 1'b0;
    int         exp_pw = 3;
    int         exp_gap = 2;
    int         busy_len = 4;
    bit         stall_mode = 1'b0;

    // device model state
    int         bcnt = 0;
    logic       prev_we = 1'b1;
    logic       prev_re = 1'b1;
    logic       id_mode = 1'b0;
    logic [7:0] ptr = '0;
    logic [7:0] seed = '0;
    int         lowrun = 0;
    int         highrun = 0;
    bit         seen_write = 1'b0;
    bit         stall_prev = 1'b0;
    logic [7:0] held = '0;
    int         cyc = 0;

    function automatic logic [7:0] id_byte(input logic [7:0] i);
        case (i)
            8'd0: return 8'hA7;
            8'd1: return 8'h3C;
            8'd2: return 8'h91;
            8'd3: return 8'h0E;
            default: return 8'h6B;
        endcase
    endfunction

    assign nand_dq_in = id_mode ? id_byte(ptr) : 8'(seed + 8'(ptr * 8'd3) + 8'h21);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // device model, bus monitor and stream scoreboard
    always @(negedge clk) begin
        if (rst) begin
            rb = 1'b1; prev_we = 1'b1; prev_re = 1'b1; lowrun = 0; highrun = 0;
            seen_write = 1'b0; stall_prev = 1'b0; m_ready = 1'b1;
        end else begin
            cyc++;
            if (nand_we_n && !prev_we) begin
                logic [8:0] got;
                logic [8:0] e;
                got = {nand_cle, nand_dq_out};
                e = (exp_bus.size() > 0) ? exp_bus.pop_front() : 9'h1EE;
                check(got == e && (nand_cle ^ nand_ale), cur_req, "bus byte {cle,dq}", got, e);
                check(lowrun == exp_pw, "R7", "write pulse width", lowrun, exp_pw);
                lowrun = 0;
                if (nand_cle) begin
                    if (nand_dq_out == 8'h30) begin rb = 1'b0; bcnt = busy_len; end
                    if (nand_dq_out == 8'h90) begin id_mode = 1'b1; ptr = '0; end
                    if (nand_dq_out == 8'h00) begin id_mode = 1'b0; ptr = '0; seed = '0; end
                end else if (nand_ale) begin
                    seed = seed ^ nand_dq_out;
                end
            end else if (!rb) begin
                bcnt--;
                if (bcnt <= 0) rb = 1'b1;
            end
            if (nand_re_n && !prev_re) ptr++;
            if (!nand_re_n) begin
                check(rb, "R4", "read strobe while device busy", 0, 1);
                check(!m_valid, "R9", "read strobe with byte pending", 1, 0);
            end
            if (!nand_we_n) lowrun++;
            if (!nand_we_n && prev_we) begin
                if (seen_write) check(highrun == exp_gap, "R7", "write gap", highrun, exp_gap);
                seen_write = 1'b1;
                highrun = 0;
            end
            if (nand_we_n && busy) highrun++;
            if (busy) begin
                check(nand_ce_n == exp_ce && nand_sel2 == exp_sel, "R2", "ce_n/sel2",
                      {nand_ce_n, nand_sel2}, {exp_ce, exp_sel});
                check(!nand_wp_n, "R8", "wp_n during op", nand_wp_n, 0);
            end else begin
                seen_write = 1'b0; highrun = 0;
                check(nand_ce_n == 2'b11 && !nand_sel2 && nand_we_n && nand_re_n && !m_valid,
                      "R1", "idle bus", {nand_ce_n, nand_sel2, nand_we_n, nand_re_n}, 5'b11011);
            end
            if (stall_prev)
                check(m_valid && m_data == held, "R9", "stalled byte", m_data, held);
            m_ready = stall_mode ? (cyc % 3 == 2) : 1'b1;
            if (m_valid && m_ready) begin
                logic [7:0] eb;
                eb = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                check(exp_q.size() >= 0 && m_data === eb, cur_req, "stream byte", m_data, eb);
            end
            stall_prev = m_valid && !m_ready;
            held = m_data;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
        end
    end

    task automatic run_op(input bit ident, input logic [1:0] bk, input logic [15:0] col,
                          input logic [23:0] row, input logic [2:0] cc, input logic [2:0] rc,
                          input logic [15:0] n, input int blen, input bit exp_err,
                          input bit poke, input string req);
        logic [7:0] sd;
        int w;
        @(negedge clk);
        cur_req  = req;
        exp_ce   = bk[0] ? 2'b01 : 2'b10;
        exp_sel  = bk[1];
        exp_pw   = ident ? 5 : 3;
        exp_gap  = ident ? 6 : 2;
        busy_len = blen;
        if (ident) begin
            exp_bus.push_back({1'b1, 8'hFF});
            exp_bus.push_back({1'b1, 8'h90});
            exp_bus.push_back({1'b0, 8'h00});
            for (int i = 0; i < 5; i++) exp_q.push_back(id_byte(8'(i)));
        end else begin
            sd = '0;
            exp_bus.push_back({1'b1, 8'h00});
            for (int k = 0; k < int'(cc); k++) begin
                exp_bus.push_back({1'b0, 8'(col >> (8 * k))});
                sd = sd ^ 8'(col >> (8 * k));
            end
            for (int k = 0; k < int'(rc); k++) begin
                exp_bus.push_back({1'b0, 8'(row >> (8 * k))});
                sd = sd ^ 8'(row >> (8 * k));
            end
            exp_bus.push_back({1'b1, 8'h30});
            if (!exp_err)
                for (int i = 0; i < int'(n); i++) exp_q.push_back(8'(sd + 8'(i * 3) + 8'h21));
        end
        op_ident = ident; bank = bk; col_addr = col; row_addr = row;
        col_cycles = cc; row_cycles = rc; byte_count = n; start = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
            start = poke && (w == 20);
            if (poke && w == 20) begin
                op_ident = ~ident; bank = ~bk; byte_count = n + 16'd9;
                col_addr = ~col; row_addr = ~row;
            end
        end while (!(done || err) && w < 6000);
        start = 1'b0;
        check(done == !exp_err, exp_err ? "R10" : "R11", "done pulse", done, !exp_err);
        check(err == exp_err, "R10", "err pulse", err, exp_err);
        check(nand_ce_n == 2'b11 && !busy, "R11", "bank released at end", nand_ce_n, 3);
        check(exp_q.size() == 0, req, "missing stream bytes", exp_q.size(), 0);
        check(exp_bus.size() == 0, req, "missing bus bytes", exp_bus.size(), 0);
        @(negedge clk);
        check(!done && !err, "R11", "single-cycle end pulse", {done, err}, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            check(!busy, "R12", "no op launched by ignored start", busy, 0);
        end
        while (!rb) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !m_valid && nand_ce_n == 2'b11 && !nand_sel2,
              "R1", "reset state", {busy, done, err, m_valid, nand_ce_n}, 6'b000011);

        // R3: identify on bank 0 with slow timing
        run_op(1'b1, 2'd0, 16'h0, 24'h0, 3'd0, 3'd0, 16'd0, 4, 1'b0, 1'b0, "R3");
        // R4 R5: full page read on bank 1
        run_op(1'b0, 2'd1, 16'h1234, 24'h56789A, 3'd2, 3'd3, 16'd6, 10, 1'b0, 1'b0, "R4");
        // R9: stalled consumer on bank 2
        stall_mode = 1'b1;
        run_op(1'b0, 2'd2, 16'hABCD, 24'h00F00D, 3'd1, 3'd2, 16'd8, 6, 1'b0, 1'b0, "R9");
        stall_mode = 1'b0;
        // R5: no column bytes, one row byte, bank 3
        run_op(1'b0, 2'd3, 16'h7777, 24'h0000C3, 3'd0, 3'd1, 16'd3, 3, 1'b0, 1'b0, "R5");
        // R2 R3: identify on bank 3 drives the secondary select
        run_op(1'b1, 2'd3, 16'h0, 24'h0, 3'd0, 3'd0, 16'd0, 4, 1'b0, 1'b0, "R3");
        // R6: zero byte count
        run_op(1'b0, 2'd0, 16'h0102, 24'h030405, 3'd2, 3'd3, 16'd0, 5, 1'b0, 1'b0, "R6");
        check(ptr == 8'd0, "R6", "read strobes on zero count", ptr, 0);
        // R10: ready seen on the final permitted wait cycle
        run_op(1'b0, 2'd1, 16'h0A0B, 24'h0C0D0E, 3'd2, 3'd3, 16'd2, TMO, 1'b0, 1'b0, "R10");
        // R10: ready one cycle late, abort
        run_op(1'b0, 2'd1, 16'h0A0B, 24'h0C0D0E, 3'd2, 3'd3, 16'd2, TMO + 1, 1'b1, 1'b0, "R10");
        check(ptr == 8'd0, "R10", "read strobes after abort", ptr, 0);
        // R12: start and input changes mid-operation ignored
        run_op(1'b0, 2'd2, 16'h4455, 24'h667788, 3'd2, 3'd3, 16'd4, 8, 1'b0, 1'b1, "R12");
        // R5: column cycles beyond field width send zero
        run_op(1'b0, 2'd0, 16'hBEEF, 24'h123456, 3'd3, 3'd2, 16'd2, 2, 1'b0, 1'b0, "R5");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule